// File: doc/BRIEF.md
# Time-Aware Transmission Gate Scheduler

This block drives the eight per-priority transmit gates of one Ethernet egress port from a cyclic gate control list. Gate output n is high while frames of priority n may be selected for transmission and low while that queue is blocked. Software prepares an administrative list while the block is in its reset run state. The list is a base time, a cycle time, an entry count and up to `N_ENT` entries, each an 8-bit gate mask with a 32-bit duration in nanoseconds. Software then switches the block to its enable state.

From then on the block watches a free-running nanosecond time input. At the start time it copies the administrative list into its own operational list and walks the entries cycle after cycle. If the durations add up to less than the cycle, an all-closed entry fills the rest of the cycle. If they add up to more, the cycle boundary cuts the list short. A sticky status flag reports that the operational list has been loaded. An index output names the entry in force.

List entries arrive over a valid/ready write stream. `ent_ready` is high only in the reset run state, so a write offered in any other state stalls until software returns the block to reset. The run state and the administrative base, cycle and count are plain level inputs. The block samples them when the enable state is entered.

Top module: `txgate_scheduler`

## Requirements
- R1: Gate output n follows bit n of the mask of the entry in force (mask 0xC0 opens only gates 7 and 6), while the schedule runs in the enable state.
- R2: `run_state` is encoded 0 = reset, 1 = enable, 2 (or 3) = disable. In reset the block holds every gate open, clears the operational list, drives `oper_updated` low and `cur_entry` to 0, and raises `ent_ready`.
- R3: In the disable state every gate is held open and `cur_entry` reads 0. `oper_updated` keeps its value.
- R4: A list entry is written when `ent_valid` and `ent_ready` are both high at a clock edge, at slot `ent_idx`. A write to a slot at or above `N_ENT` is dropped. `ent_ready` is low outside the reset state.
- R5: On entering the enable state the block samples `adm_base`, `adm_cycle` and `adm_len`, with the count clamped to `N_ENT`. Until the start time all gates stay open and no new list is loaded. At the start time the operational list takes the administrative values, entry 0 comes into force and `oper_updated` rises.
- R6: With start time S, entry k covers S + d0 + … + d(k−1) through that value + dk − 1, and the next entry starts on the following nanosecond. The outputs after a clock edge reflect the time value presented at that edge, and `cur_entry` gives the index of the entry in force.
- R7: When the durations sum to less than the cycle, the remainder of each cycle is an entry with index `adm_len` and all gates closed.
- R8: Every cycle boundary S + m·cycle returns the schedule to entry 0. An entry that runs past the boundary is truncated there.
- R9: If the base time is earlier than the current time when the enable state is entered, the start time is the first base + k·cycle that is not earlier than the time at which the block evaluates it (a few clocks after entry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_ns | input | TIME_W | Free-running nanosecond time |
| run_state | input | 2 | Run state: 0 reset, 1 enable, 2/3 disable |
| adm_base | input | TIME_W | Administrative base time |
| adm_cycle | input | DUR_W | Administrative cycle time in ns |
| adm_len | input | IDX_W | Number of administrative entries |
| ent_valid | input | 1 | Entry write offered |
| ent_ready | output | 1 | Entry write accepted (reset state only) |
| ent_idx | input | IDX_W | Slot of the entry written |
| ent_mask | input | GATES | Gate mask of the entry written |
| ent_dur | input | DUR_W | Duration of the entry written, ns |
| gate_open | output | GATES | Per-priority gate open |
| oper_updated | output | 1 | Operational list has been loaded |
| cur_entry | output | IDX_W | Index of the entry in force |

## Verification
The assertions assume several things about the inputs. `time_ns` never goes backwards and never advances by more than the shortest entry duration in one clock. Every duration and the cycle time are at least a few clocks of time. A past base time lies no more than a few cycles behind the current time, so catch-up ends well before the start. The stimulus advances time by exactly one nanosecond per clock, with durations of at least 10 ns and cycles of at least 60 ns. It places a past base time so that the two neighbouring candidate start times lie clearly on either side of the evaluation point.

// File: rtl/txgate_pkg.sv
package txgate_pkg;
  localparam logic [1:0] RS_RESET  = 2'd0;
  localparam logic [1:0] RS_ENABLE = 2'd1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CATCH = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;
endpackage

// File: rtl/txgate_admin_store.sv
module txgate_admin_store #(
  parameter int N_ENT = 16,
  parameter int GATES = 8,
  parameter int DUR_W = 32,
  parameter int IDX_W = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_reset,
  input  logic                             ent_valid,
  output logic                             ent_ready,
  input  logic [IDX_W-1:0]                 ent_idx,
  input  logic [GATES-1:0]                 ent_mask,
  input  logic [DUR_W-1:0]                 ent_dur,
  output logic [N_ENT-1:0][GATES-1:0]      adm_mask,
  output logic [N_ENT-1:0][DUR_W-1:0]      adm_dur
);
  logic wr_fire;

  assign ent_ready = in_reset;
  assign wr_fire   = ent_valid && ent_ready;

  for (genvar k = 0; k < N_ENT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        adm_mask[k] <= '0;
        adm_dur[k]  <= '0;
      end else if (wr_fire && (ent_idx == IDX_W'(k))) begin
        adm_mask[k] <= ent_mask;
        adm_dur[k]  <= ent_dur;
      end
    end
  end

  AST_ADMIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reset |=> ($stable(adm_mask) && $stable(adm_dur))); // R4
endmodule

// File: rtl/txgate_start_ctrl.sv
module txgate_start_ctrl
  import txgate_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int DUR_W  = 32,
  parameter int TIME_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              abort,
  input  logic [TIME_W-1:0] time_ns,
  input  logic [TIME_W-1:0] base_in,
  input  logic [DUR_W-1:0]  cycle_in,
  input  logic [IDX_W-1:0]  len_in,
  output logic              swap,
  output logic [TIME_W-1:0] start_t,
  output logic [DUR_W-1:0]  cycle_p,
  output logic [IDX_W-1:0]  len_p
);
  localparam logic [IDX_W-1:0] LEN_MAX = IDX_W'(N_ENT);

  phase_e            phase;
  logic [TIME_W-1:0] cycle_ext;

  assign cycle_ext = TIME_W'(cycle_p);
  assign swap      = (phase == PH_WAIT) && !abort && (time_ns >= start_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      start_t <= '0;
      cycle_p <= '0;
      len_p   <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
    end else if (arm) begin
      phase   <= PH_CATCH;
      start_t <= base_in;
      cycle_p <= cycle_in;
      len_p   <= (len_in > LEN_MAX) ? LEN_MAX : len_in;
    end else begin
      case (phase)
        PH_CATCH: begin
          if (cycle_p == '0) begin
            phase <= PH_IDLE;
          end else if (start_t < time_ns) begin
            start_t <= start_t + cycle_ext;
          end else begin
            phase <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (swap) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_START_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_WAIT) |-> (start_t >= $past(time_ns))); // R9
endmodule

// File: rtl/txgate_walker.sv
module txgate_walker #(
  parameter int N_ENT  = 16,
  parameter int GATES  = 8,
  parameter int DUR_W  = 32,
  parameter int TIME_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        halt,
  input  logic                        swap,
  input  logic [TIME_W-1:0]           time_ns,
  input  logic [TIME_W-1:0]           start_t,
  input  logic [DUR_W-1:0]            cycle_p,
  input  logic [IDX_W-1:0]            len_p,
  input  logic [N_ENT-1:0][GATES-1:0] adm_mask,
  input  logic [N_ENT-1:0][DUR_W-1:0] adm_dur,
  output logic                        running,
  output logic                        oper_updated,
  output logic [IDX_W-1:0]            cur_idx,
  output logic [GATES-1:0]            cur_mask
);
  logic [N_ENT-1:0][GATES-1:0] op_mask;
  logic [N_ENT-1:0][DUR_W-1:0] op_dur;
  logic [IDX_W-1:0]            op_len;
  logic [DUR_W-1:0]            op_cycle;
  logic [TIME_W-1:0]           cyc_end;
  logic [TIME_W-1:0]           entry_end;
  logic [IDX_W-1:0]            nxt_idx;

  function automatic logic [DUR_W-1:0] pick_dur(
      input logic [N_ENT-1:0][DUR_W-1:0] arr, input logic [IDX_W-1:0] sel);
    logic [DUR_W-1:0] r;
    r = '0;
    for (int k = 0; k < N_ENT; k++)
      if (sel == IDX_W'(k)) r = arr[k];
    return r;
  endfunction

  function automatic logic [GATES-1:0] pick_mask(
      input logic [N_ENT-1:0][GATES-1:0] arr, input logic [IDX_W-1:0] sel);
    logic [GATES-1:0] r;
    r = '0;
    for (int k = 0; k < N_ENT; k++)
      if (sel == IDX_W'(k)) r = arr[k];
    return r;
  endfunction

  assign nxt_idx  = cur_idx + IDX_W'(1);
  assign cur_mask = (cur_idx < op_len) ? pick_mask(op_mask, cur_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mask      <= '0;
      op_dur       <= '0;
      op_len       <= '0;
      op_cycle     <= '0;
      cyc_end      <= '0;
      entry_end    <= '0;
      cur_idx      <= '0;
      running      <= 1'b0;
      oper_updated <= 1'b0;
    end else if (clear) begin
      op_mask      <= '0;
      op_dur       <= '0;
      op_len       <= '0;
      op_cycle     <= '0;
      cur_idx      <= '0;
      running      <= 1'b0;
      oper_updated <= 1'b0;
    end else if (halt) begin
      cur_idx <= '0;
      running <= 1'b0;
    end else if (swap) begin
      op_mask      <= adm_mask;
      op_dur       <= adm_dur;
      op_len       <= len_p;
      op_cycle     <= cycle_p;
      cyc_end      <= start_t + TIME_W'(cycle_p);
      entry_end    <= start_t + TIME_W'(adm_dur[0]);
      cur_idx      <= '0;
      running      <= 1'b1;
      oper_updated <= 1'b1;
    end else if (running) begin
      if (time_ns >= cyc_end) begin
        cyc_end   <= cyc_end + TIME_W'(op_cycle);
        entry_end <= cyc_end + TIME_W'(op_dur[0]);
        cur_idx   <= '0;
      end else if ((cur_idx < op_len) && (time_ns >= entry_end)) begin
        cur_idx   <= nxt_idx;
        entry_end <= (nxt_idx < op_len) ? entry_end + TIME_W'(pick_dur(op_dur, nxt_idx))
                                        : cyc_end;
      end
    end
  end

  AST_SWAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !clear && !halt) |=> (running && oper_updated && cur_idx == '0)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!oper_updated && !running && op_len == '0)); // R2
  AST_CYCLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !clear && !halt && !swap && time_ns >= cyc_end) |=> (cur_idx == '0)); // R8
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && cur_idx != $past(cur_idx))
      |-> (cur_idx == '0 || cur_idx == $past(cur_idx) + IDX_W'(1))); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cur_idx <= op_len)); // R7
endmodule

// File: rtl/txgate_scheduler.sv
module txgate_scheduler
  import txgate_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int GATES  = 8,
  parameter int DUR_W  = 32,
  parameter int TIME_W = 64,
  parameter int IDX_W  = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_ns,
  input  logic [1:0]        run_state,
  input  logic [TIME_W-1:0] adm_base,
  input  logic [DUR_W-1:0]  adm_cycle,
  input  logic [IDX_W-1:0]  adm_len,
  input  logic              ent_valid,
  output logic              ent_ready,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [GATES-1:0]  ent_mask,
  input  logic [DUR_W-1:0]  ent_dur,
  output logic [GATES-1:0]  gate_open,
  output logic              oper_updated,
  output logic [IDX_W-1:0]  cur_entry
);
  logic                        in_reset, in_enable, en_q, arm;
  logic                        swap, running;
  logic [TIME_W-1:0]           start_t;
  logic [DUR_W-1:0]            cycle_p;
  logic [IDX_W-1:0]            len_p, walk_idx;
  logic [GATES-1:0]            walk_mask;
  logic [N_ENT-1:0][GATES-1:0] adm_mask;
  logic [N_ENT-1:0][DUR_W-1:0] adm_dur;

  assign in_reset  = (run_state == RS_RESET);
  assign in_enable = (run_state == RS_ENABLE);
  assign arm       = in_enable && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= in_enable;
  end

  txgate_admin_store #(.N_ENT(N_ENT), .GATES(GATES), .DUR_W(DUR_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .in_reset(in_reset),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_idx(ent_idx),
    .ent_mask(ent_mask), .ent_dur(ent_dur),
    .adm_mask(adm_mask), .adm_dur(adm_dur));

  txgate_start_ctrl #(.N_ENT(N_ENT), .DUR_W(DUR_W), .TIME_W(TIME_W), .IDX_W(IDX_W)) u_start (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(!in_enable),
    .time_ns(time_ns), .base_in(adm_base), .cycle_in(adm_cycle), .len_in(adm_len),
    .swap(swap), .start_t(start_t), .cycle_p(cycle_p), .len_p(len_p));

  txgate_walker #(.N_ENT(N_ENT), .GATES(GATES), .DUR_W(DUR_W), .TIME_W(TIME_W),
                  .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clear(in_reset), .halt(!in_enable), .swap(swap),
    .time_ns(time_ns), .start_t(start_t), .cycle_p(cycle_p), .len_p(len_p),
    .adm_mask(adm_mask), .adm_dur(adm_dur),
    .running(running), .oper_updated(oper_updated),
    .cur_idx(walk_idx), .cur_mask(walk_mask));

  assign gate_open = running ? walk_mask : '1;
  assign cur_entry = walk_idx;

  AST_IDLE_GATES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_enable |=> (gate_open == '1 && cur_entry == '0)); // R3
  AST_NO_WRITE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reset |-> !ent_ready); // R4
endmodule

// File: tb/txgate_scheduler_tb_top.sv
module txgate_scheduler_tb_top;
  localparam int N_ENT = 16, GATES = 8, DUR_W = 32, TIME_W = 64;
  localparam int IDX_W = $clog2(N_ENT + 1);
  localparam int NV = 14;
  // {offset[15:0], mask[7:0], index[7:0]} for schedule 1 (start 400)
  localparam logic [31:0] VEC [NV] = '{
    {16'd0,   8'hC0, 8'd0}, {16'd9,   8'hC0, 8'd0}, {16'd10,  8'h30, 8'd1},
    {16'd19,  8'h30, 8'd1}, {16'd20,  8'h0C, 8'd2}, {16'd29,  8'h0C, 8'd2},
    {16'd30,  8'h03, 8'd3}, {16'd39,  8'h03, 8'd3}, {16'd40,  8'h00, 8'd4},
    {16'd59,  8'h00, 8'd4}, {16'd60,  8'hC0, 8'd0}, {16'd75,  8'h30, 8'd1},
    {16'd100, 8'h00, 8'd4}, {16'd120, 8'hC0, 8'd0}};

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [TIME_W-1:0] time_ns = '0;
  logic [1:0]        run_state = 2'd0;
  logic [TIME_W-1:0] adm_base = '0;
  logic [DUR_W-1:0]  adm_cycle = '0;
  logic [IDX_W-1:0]  adm_len = '0;
  logic              ent_valid = 1'b0;
  logic              ent_ready;
  logic [IDX_W-1:0]  ent_idx = '0;
  logic [GATES-1:0]  ent_mask = '0;
  logic [DUR_W-1:0]  ent_dur = '0;
  logic [GATES-1:0]  gate_open;
  logic              oper_updated;
  logic [IDX_W-1:0]  cur_entry;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(negedge clk) time_ns <= time_ns + 1;

  txgate_scheduler #(.N_ENT(N_ENT), .GATES(GATES), .DUR_W(DUR_W), .TIME_W(TIME_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .run_state(run_state),
    .adm_base(adm_base), .adm_cycle(adm_cycle), .adm_len(adm_len),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_idx(ent_idx),
    .ent_mask(ent_mask), .ent_dur(ent_dur),
    .gate_open(gate_open), .oper_updated(oper_updated), .cur_entry(cur_entry));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at t=%0d: actual %0h expected %0h", req, time_ns, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_time(input logic [TIME_W-1:0] t);
    do step(); while (time_ns != t);
  endtask

  task automatic write_ent(input int idx, input logic [7:0] m, input int d);
    @(negedge clk);
    ent_valid = 1'b1; ent_idx = IDX_W'(idx); ent_mask = m; ent_dur = DUR_W'(d);
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  initial begin
    logic [TIME_W-1:0] v, s2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R2: reset state
    check("R2 gates after reset", 32'(gate_open), 32'hFF);
    check("R2 updated after reset", 32'(oper_updated), 0);
    check("R2 entry after reset", 32'(cur_entry), 0);
    check("R2 ready in reset", 32'(ent_ready), 1);

    // schedule 1: four 10 ns entries in a 60 ns cycle, base 400
    write_ent(0, 8'hC0, 10);
    write_ent(1, 8'h30, 10);
    write_ent(2, 8'h0C, 10);
    write_ent(3, 8'h03, 10);
    write_ent(20, 8'hFF, 5);   // slot beyond depth, dropped (R4)
    @(negedge clk);
    adm_base = 400; adm_cycle = 60; adm_len = 4;
    run_state = 2'd1;
    step();
    check("R4 ready low in enable", 32'(ent_ready), 0);
    wait_time(399);
    check("R5 gates open before start", 32'(gate_open), 32'hFF);
    check("R5 no update before start", 32'(oper_updated), 0);
    for (int i = 0; i < NV; i++) begin
      wait_time(400 + TIME_W'(VEC[i][31:16]));
      check("R1/R6/R7/R8 gate mask", 32'(gate_open), 32'(VEC[i][15:8]));
      check("R6 entry index", 32'(cur_entry), 32'(VEC[i][7:0]));
      check("R5 updated flag", 32'(oper_updated), 1);
    end

    // R3: disable
    @(negedge clk); run_state = 2'd2;
    step();
    check("R3 gates open in disable", 32'(gate_open), 32'hFF);
    check("R3 entry in disable", 32'(cur_entry), 0);
    check("R3 updated kept", 32'(oper_updated), 1);
    check("R4 ready low in disable", 32'(ent_ready), 0);
    step(); step();
    check("R3 gates stay open", 32'(gate_open), 32'hFF);

    // R2: back to reset clears
    @(negedge clk); run_state = 2'd0;
    step();
    check("R2 updated cleared", 32'(oper_updated), 0);
    check("R2 gates open", 32'(gate_open), 32'hFF);
    check("R2 ready in reset", 32'(ent_ready), 1);

    // schedule 2: 3 x 30 ns in a 70 ns cycle (truncation), base in the past
    write_ent(0, 8'h01, 30);
    write_ent(1, 8'h02, 30);
    write_ent(2, 8'h04, 30);
    step();
    v = time_ns;
    @(negedge clk);
    adm_base = v - 129; adm_cycle = 70; adm_len = 3;
    run_state = 2'd1;
    s2 = adm_base;
    while (s2 < v + 4) s2 = s2 + 70;
    wait_time(s2 - 1);
    check("R9 not started early", 32'(gate_open), 32'hFF);
    wait_time(s2);
    check("R9 start at boundary", 32'(gate_open), 32'h01);
    check("R9 updated at start", 32'(oper_updated), 1);
    wait_time(s2 + 29);
    check("R6 last ns of entry 0", 32'(gate_open), 32'h01);
    wait_time(s2 + 30);
    check("R6 entry 1 begins", 32'(cur_entry), 1);
    wait_time(s2 + 60);
    check("R8 entry 2 before cut", 32'(gate_open), 32'h04);
    wait_time(s2 + 69);
    check("R8 entry 2 last ns", 32'(cur_entry), 2);
    wait_time(s2 + 70);
    check("R8 truncated, restart mask", 32'(gate_open), 32'h01);
    check("R8 truncated, restart index", 32'(cur_entry), 0);
    wait_time(s2 + 100);
    check("R8 second cycle entry 1", 32'(gate_open), 32'h02);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule